// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Block

This block holds a set of independent timer channels behind one 32-bit register port. Each channel keeps a terminal-count value apart from its running counter. On every tick from the source picked by its control register, the running counter steps down by one. When the counter reaches zero, the channel raises an interrupt flag. If reload is on, the next tick after zero refills the counter from the terminal-count value. If reload is off, the counter stays at zero, which gives one-shot operation. A second control bit chooses what a write to the terminal count does: it either loads the running counter in the same cycle or waits for the next refill.

Software arms an event by writing a count. Tick sources come in as single-cycle enables that are synchronous to the bus clock, one per source code. Source code 0 means no tick at all. Source code 11 is intended for the slow crystal tick. The control register has two write aliases, one that sets bits and one that clears bits, so the interrupt enable or flag can be changed without a read-modify-write. A write to the global control word returns every channel to its reset state. A fixed version word reports major version 2.

Top module: `rtimer_dual`

## Requirements
- R1: After reset, every control, terminal-count and running-count register reads 0, every irq bit is low, and the word at byte offset 0x120 reads 0x0200_0000 (major version 2 in bits 31:24).
- R2: Channel n has its control register at byte offset 0x20+0x40*n. Control bits 3:0 pick the tick source: code k (1..15) uses tick_src[k], and code 0 means no tick. Each tick from the chosen source lowers the running count (offset 0x30+0x40*n) by one. Ticks on other sources, and all ticks under code 0, leave it unchanged.
- R3: A write to the terminal count (offset 0x40+0x40*n) while update (control bit 7) is 1 loads the running count with the written value in the same cycle. While update is 0 the running count is unchanged and only the terminal count takes the new value.
- R4: The tick that moves the running count from 1 to 0 sets the flag (control bit 15). The irq of the channel is high exactly when the flag and the interrupt enable (control bit 14) are both 1.
- R5: With reload (control bit 6) at 1, a tick while the count is 0 loads the terminal count. With reload at 0, the count stays at 0 under further ticks (one-shot).
- R6: A write to control+4 sets the written 1 bits, and a write to control+8 clears the written 1 bits. In both cases every other control bit keeps its value.
- R7: Software clears the flag by writing 0 to bit 15, either by a plain write or through the clear alias. A hardware set in the same cycle as a software clear wins, so the flag ends at 1.
- R8: With reload on and the terminal count at all ones, the counter wraps from 0 back to all ones and keeps running.
- R9: A write to byte offset 0x00 with bit 0 set returns every channel's registers to their reset values and drops all irq bits.
- R10: A write to a running-count offset has no effect. Writes to one channel never change the registers of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| tick_src | input | 16 | Tick enables, one per source code |
| irq | output | NUM_CH | Per-channel interrupt, flag AND enable |

## Verification
The bench builds the block with two channels and an 8-bit counter. With the 8-bit counter, a full wrap from all ones through zero and back takes only 256 ticks, so the free-running case is driven end to end. Every one of the 16 source codes is swept against every tick line. Reload periods from one to six ticks are walked one by one, and each flag and count is compared with arithmetic done in the bench. The case where a flag clear and a hardware set land in the same cycle is driven on purpose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W        = 4;
  localparam int NUM_SRC      = 2 ** SEL_W;
  localparam int DATA_W       = 32;
  localparam int CH_STRIDE    = 'h40;
  localparam int CTRL_BASE    = 'h20;
  localparam int CNT_OFS      = 'h10;
  localparam int FIX_OFS      = 'h20;
  localparam int SET_OFS      = 'h4;
  localparam int CLR_OFS      = 'h8;
  localparam int GCTRL_ADDR   = 'h00;
  localparam int VERSION_ADDR = 'h120;
  localparam logic [DATA_W-1:0] VERSION_WORD = 32'h0200_0000;
  localparam int B_RELOAD = 6;
  localparam int B_UPDATE = 7;
  localparam int B_IEN    = 14;
  localparam int B_FLAG   = 15;
  localparam int B_SRST   = 0;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  logic [NUM_SRC-1:0] src,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  // code 0 is reserved for "no tick"
  assign tick = (sel != '0) && src[sel];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               ctrl_we,
  input  logic               ctrl_set,
  input  logic               ctrl_clr,
  input  logic               fix_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic [DATA_W-1:0]  ctrl_rd,
  output logic [DATA_W-1:0]  cnt_rd,
  output logic [DATA_W-1:0]  fix_rd,
  output logic               irq
);
  logic [SEL_W-1:0] sel_q;
  logic             rld_q, upd_q, ien_q, flg_q;
  logic [CNT_W-1:0] cnt_q, fix_q;
  logic [DATA_W-1:0] ctrl_cur, ctrl_nxt;
  logic tick, load_now, hit;

  tmr_tick_sel u_sel (.src(tick_src), .sel(sel_q), .tick(tick));

  always_comb begin
    ctrl_cur = '0;
    ctrl_cur[SEL_W-1:0] = sel_q;
    ctrl_cur[B_RELOAD]  = rld_q;
    ctrl_cur[B_UPDATE]  = upd_q;
    ctrl_cur[B_IEN]     = ien_q;
    ctrl_cur[B_FLAG]    = flg_q;
    if (ctrl_we)       ctrl_nxt = wdata;
    else if (ctrl_set) ctrl_nxt = ctrl_cur | wdata;
    else if (ctrl_clr) ctrl_nxt = ctrl_cur & ~wdata;
    else               ctrl_nxt = ctrl_cur;
  end

  assign load_now = fix_we && upd_q;
  assign hit      = tick && !load_now && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; rld_q <= 1'b0; upd_q <= 1'b0; ien_q <= 1'b0; flg_q <= 1'b0;
      cnt_q <= '0; fix_q <= '0;
    end else if (srst) begin
      sel_q <= '0; rld_q <= 1'b0; upd_q <= 1'b0; ien_q <= 1'b0; flg_q <= 1'b0;
      cnt_q <= '0; fix_q <= '0;
    end else begin
      sel_q <= ctrl_nxt[SEL_W-1:0];
      rld_q <= ctrl_nxt[B_RELOAD];
      upd_q <= ctrl_nxt[B_UPDATE];
      ien_q <= ctrl_nxt[B_IEN];
      flg_q <= ctrl_nxt[B_FLAG] | hit;   // hardware set wins over a clear
      if (fix_we) fix_q <= wdata[CNT_W-1:0];
      if (load_now)
        cnt_q <= wdata[CNT_W-1:0];
      else if (tick) begin
        if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
        else if (rld_q)   cnt_q <= fix_q;
      end
    end
  end

  assign ctrl_rd = ctrl_cur;
  assign cnt_rd  = DATA_W'(cnt_q);
  assign fix_rd  = DATA_W'(fix_q);
  assign irq     = flg_q && ien_q;

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && !load_now && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !srst && !load_now) |=> $stable(cnt_q));
  assert_flag_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !srst) |=> flg_q && cnt_q == '0);
  assert_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !srst && !load_now && cnt_q == '0 && rld_q) |=> cnt_q == $past(fix_q));
  assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !rld_q && !srst && !load_now) |=> cnt_q == '0);
  assert_update_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !srst) |=> cnt_q == $past(wdata[CNT_W-1:0]));
endmodule

// File: rtl/rtimer_dual.sv
module rtimer_dual
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic [NUM_CH-1:0]  irq
);
  logic [DATA_W-1:0] ctrl_rd [NUM_CH];
  logic [DATA_W-1:0] cnt_rd  [NUM_CH];
  logic [DATA_W-1:0] fix_rd  [NUM_CH];
  logic srst;

  assign srst = bus_wr && (bus_addr == ADDR_W'(GCTRL_ADDR)) && bus_wdata[B_SRST];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int CB = CTRL_BASE + n * CH_STRIDE;
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .ctrl_we  (bus_wr && bus_addr == ADDR_W'(CB)),
      .ctrl_set (bus_wr && bus_addr == ADDR_W'(CB + SET_OFS)),
      .ctrl_clr (bus_wr && bus_addr == ADDR_W'(CB + CLR_OFS)),
      .fix_we   (bus_wr && bus_addr == ADDR_W'(CB + FIX_OFS)),
      .wdata    (bus_wdata),
      .tick_src (tick_src),
      .ctrl_rd  (ctrl_rd[n]),
      .cnt_rd   (cnt_rd[n]),
      .fix_rd   (fix_rd[n]),
      .irq      (irq[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(VERSION_ADDR)) bus_rdata = VERSION_WORD;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(CTRL_BASE + i * CH_STRIDE))           bus_rdata = ctrl_rd[i];
      if (bus_addr == ADDR_W'(CTRL_BASE + i * CH_STRIDE + CNT_OFS)) bus_rdata = cnt_rd[i];
      if (bus_addr == ADDR_W'(CTRL_BASE + i * CH_STRIDE + FIX_OFS)) bus_rdata = fix_rd[i];
    end
  end

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> irq == '0);
endmodule

// File: tb/rtimer_dual_test.sv
module rtimer_dual_test;
  localparam int W = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] tick_src = '0;
  logic [1:0]  irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  rtimer_dual #(.NUM_CH(2), .CNT_W(W), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src), .irq(irq));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [11:0] cb(int n); return 12'(32'h20 + n * 32'h40); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic tk(int s, int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); tick_src = 16'(1 << s);
      @(negedge clk); tick_src = '0;
    end
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int n = 0; n < 2; n++) begin
      rd(cb(n), v);         chk("R1 ctrl", v, 0);
      rd(cb(n) + 12'h10, v); chk("R1 cnt", v, 0);
      rd(cb(n) + 12'h20, v); chk("R1 fix", v, 0);
    end
    chk("R1 irq", 32'(irq), 0);
    rd(12'h120, v); chk("R1 version", v, 32'h0200_0000);

    // R2 sweep every select code against every tick line
    for (int sel = 0; sel < 16; sel++) begin
      wr(cb(0), 32'h80 | sel);
      wr(cb(0) + 12'h20, 100);
      for (int s = 1; s < 16; s++) begin
        tk(s, 1);
        rd(cb(0) + 12'h10, v);
        chk("R2 select", v, (sel != 0 && s >= sel) ? 99 : 100);
      end
    end

    // R3 update off: only fixed changes; R5 refill then one-shot
    wr(cb(0), 32'h81);
    wr(cb(0) + 12'h20, 20);
    wr(cb(0) + 12'h8, 32'h80);
    wr(cb(0) + 12'h20, 50);
    rd(cb(0) + 12'h10, v); chk("R3 no update cnt", v, 20);
    rd(cb(0) + 12'h20, v); chk("R3 fixed value", v, 50);
    wr(cb(0) + 12'h4, 32'h40);
    tk(1, 20);
    rd(cb(0) + 12'h10, v); chk("R4 reach zero", v, 0);
    rd(cb(0), v); chk("R4 flag set", v[15], 1);
    chk("R4 irq off without enable", 32'(irq[0]), 0);
    wr(cb(0) + 12'h4, 32'h4000);
    chk("R4 irq on", 32'(irq[0]), 1);
    tk(1, 1);
    rd(cb(0) + 12'h10, v); chk("R5 refill", v, 50);
    wr(cb(0) + 12'h8, 32'h8000);
    chk("R7 clear flag irq", 32'(irq[0]), 0);

    // R5 reload period sweep
    for (int f = 1; f <= 6; f++) begin
      wr(cb(0), 32'h40C1);
      wr(cb(0) + 12'h20, f);
      tk(1, f - 1);
      rd(cb(0), v); chk("R5 no early flag", v[15], 0);
      tk(1, 1);
      rd(cb(0), v); chk("R5 flag at period", v[15], 1);
      tk(1, 1);
      rd(cb(0) + 12'h10, v); chk("R5 period refill", v, f);
    end

    // R5 one-shot holds at zero
    wr(cb(0), 32'h81);
    wr(cb(0) + 12'h20, 3);
    tk(1, 5);
    rd(cb(0) + 12'h10, v); chk("R5 one-shot hold", v, 0);

    // R6 aliases
    wr(cb(0), 32'h4041);
    wr(cb(0) + 12'h4, 32'h80);
    rd(cb(0), v); chk("R6 set alias", v, 32'h40C1);
    wr(cb(0) + 12'h8, 32'h40);
    rd(cb(0), v); chk("R6 clear alias", v, 32'h4081);

    // R7 hardware set beats same-cycle clear
    wr(cb(0) + 12'h20, 1);
    @(negedge clk); bus_addr = cb(0) + 12'h8; bus_wdata = 32'h8000; bus_wr = 1'b1; tick_src = 16'h2;
    @(negedge clk); bus_wr = 1'b0; tick_src = '0;
    rd(cb(0), v); chk("R7 set wins", v[15], 1);
    wr(cb(0), 32'h0);
    rd(cb(0), v); chk("R7 plain write clears", v, 0);

    // R8 free-running wrap
    wr(cb(0), 32'hC1);
    wr(cb(0) + 12'h20, 32'hFF);
    tk(1, 255);
    rd(cb(0) + 12'h10, v); chk("R8 at zero", v, 0);
    tk(1, 1);
    rd(cb(0) + 12'h10, v); chk("R8 wrapped", v, 32'hFF);

    // R10 independence and read-only count
    wr(cb(1), 32'h4082);
    wr(cb(1) + 12'h20, 7);
    wr(cb(1) + 12'h10, 33);
    rd(cb(1) + 12'h10, v); chk("R10 ro count", v, 7);
    rd(cb(0) + 12'h10, v); chk("R10 ch0 untouched", v, 32'hFF);
    tk(1, 2);
    rd(cb(1) + 12'h10, v); chk("R10 ch1 ignores src1", v, 7);
    tk(2, 7);
    chk("R10 ch1 irq", 32'(irq), 2);

    // R9 global soft reset
    wr(12'h000, 1);
    chk("R9 irq low", 32'(irq), 0);
    for (int n = 0; n < 2; n++) begin
      rd(cb(n), v);          chk("R9 ctrl", v, 0);
      rd(cb(n) + 12'h10, v); chk("R9 cnt", v, 0);
      rd(cb(n) + 12'h20, v); chk("R9 fix", v, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule